// File: doc/BRIEF.md
# Mixed-Page Translation Buffer with Write-Permission Check

This block holds a small set of address translations for one core's memory pipeline. It turns a 40-bit virtual address into a 40-bit physical address. Every slot is searched in parallel, and each slot may describe either a 4KB page or a 512KB page, so both sizes share one array. A read-only bit is stored in each slot. A store that lands on such a page is flagged as a permission fault in the same response that carries the translation.

A lookup is presented for one cycle, and the answer comes out registered in the next cycle. An external table walker loads new translations through a one-cycle write port. The slot that receives the write is chosen inside the block: the lowest free slot if there is one, otherwise a round-robin pointer. A single-cycle flush drops every translation. If overlapping entries match the same address, the lowest slot wins and an error flag reports the overlap.

Top module: `xlate_tlb`

## Requirements
- R1: After reset every slot is invalid and all response outputs are 0, so any lookup misses.
- R2: A lookup with `lk_req`=1 produces `rsp_vld`=1 exactly one cycle later, and the answer reflects the slots as they stood in the request cycle. A fill or flush in that same cycle is not seen by it.
- R3: A 4KB slot (`fill_large`=0) matches when VA[39:12] equals its stored virtual tag. The result is PA = {stored PA[39:12], VA[11:0]}.
- R4: A 512KB slot (`fill_large`=1) compares only VA[39:19]. The result is PA = {stored PA[39:19], VA[18:0]}, and bits [18:12] of the filled addresses have no effect.
- R5: `rsp_fault`=1 only when the lookup hits, `lk_store`=1 and the matching slot was filled with `fill_ro`=1. Loads to read-only pages and stores to writable pages do not fault.
- R6: On a miss `rsp_hit`, `rsp_fault`, `rsp_multi` are 0 and `rsp_pa` is 0.
- R7: A fill is written into the lowest-numbered invalid slot while any slot is invalid.
- R8: When all slots are valid, a fill replaces the slot at a round-robin pointer. The pointer is 0 after reset, advances by one after each such fill and wraps after the last slot.
- R9: `flush_all` invalidates every slot in one cycle. A fill in the same cycle is discarded.
- R10: When several slots match, the lowest-numbered one supplies the translation and permission, and `rsp_multi`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 40 | Lookup virtual address |
| lk_store | input | 1 | Lookup is a store |
| fill_en | input | 1 | Write one translation |
| fill_va | input | 40 | Virtual page address to install |
| fill_pa | input | 40 | Physical page address to install |
| fill_large | input | 1 | 1 = 512KB page, 0 = 4KB page |
| fill_ro | input | 1 | 1 = page is read-only |
| flush_all | input | 1 | Invalidate all slots |
| rsp_vld | output | 1 | Response valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 40 | Translated physical address |
| rsp_fault | output | 1 | Store to read-only page |
| rsp_multi | output | 1 | More than one slot matched |

## Verification
A lookup can share its cycle with a fill or with a flush, and a flush can share its cycle with a fill. The bench drives each pair on the same clock edge. It requires the lookup to report the pre-edge contents: a miss for an address being installed, and a hit for an address being flushed. A follow-up lookup then confirms that the fill took effect, that the flush took effect, and that a fill colliding with a flush left nothing behind.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int ADDR_W   = 40;
  localparam int SMALL_SH = 12;
  localparam int LARGE_SH = 19;
  localparam int TAG_W    = ADDR_W - SMALL_SH;
  localparam int SPAN     = LARGE_SH - SMALL_SH;

  typedef struct packed {
    logic             vld;
    logic             big;
    logic             ro;
    logic [TAG_W-1:0] vtag;
    logic [TAG_W-1:0] ptag;
  } xlt_ent_t;

  // Tag comparison; large pages ignore the low SPAN bits of the tag
  function automatic logic ent_hit(xlt_ent_t e, logic [ADDR_W-1:0] va);
    logic [TAG_W-1:0] vt;
    vt = va[ADDR_W-1:SMALL_SH];
    if (!e.vld) return 1'b0;
    if (e.big) return e.vtag[TAG_W-1:SPAN] == vt[TAG_W-1:SPAN];
    return e.vtag == vt;
  endfunction

  // Physical address assembly for the page size of the entry
  function automatic logic [ADDR_W-1:0] ent_pa(xlt_ent_t e, logic [ADDR_W-1:0] va);
    if (e.big) return {e.ptag[TAG_W-1:SPAN], va[LARGE_SH-1:0]};
    return {e.ptag, va[SMALL_SH-1:0]};
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import xlt_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  xlt_ent_t         wr_ent,
  input  logic             clr_all,
  output xlt_ent_t         ents [N_ENT],
  output logic [N_ENT-1:0] valid_vec
);
  xlt_ent_t ent_q [N_ENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
    end else if (clr_all) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i].vld <= 1'b0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_out
    assign ents[g]      = ent_q[g];
    assign valid_vec[g] = ent_q[g].vld;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import xlt_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  xlt_ent_t          ents [N_ENT],
  input  logic [ADDR_W-1:0] va,
  output logic              hit_any,
  output logic              multi,
  output logic [ADDR_W-1:0] pa_sel,
  output logic              ro_sel
);
  logic [N_ENT-1:0] hit_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = ent_hit(ents[g], va);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    pa_sel = '0;
    ro_sel = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        pa_sel = ent_pa(ents[i], va);
        ro_sel = ents[i].ro;
      end
    end
  end

  assign hit_any = |hit_vec;
  assign multi   = |(hit_vec & (hit_vec - N_ENT'(1)));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] valid_vec,
  input  logic             take,
  output logic [IDX_W-1:0] vic_idx,
  output logic             all_valid
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_valid = &valid_vec;
  assign vic_idx   = all_valid ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && all_valid) begin
      rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlt_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_va,
  input  logic              lk_store,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_va,
  input  logic [ADDR_W-1:0] fill_pa,
  input  logic              fill_large,
  input  logic              fill_ro,
  input  logic              flush_all,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_fault,
  output logic              rsp_multi
);
  xlt_ent_t          ents [N_ENT];
  xlt_ent_t          wr_ent;
  logic [N_ENT-1:0]  valid_vec;
  logic [IDX_W-1:0]  fill_idx;
  logic              fill_take;
  logic              all_valid;
  logic              m_hit, m_multi, m_ro;
  logic [ADDR_W-1:0] m_pa;

  // Flush wins over a coincident fill
  assign fill_take   = fill_en && !flush_all;
  assign wr_ent.vld  = 1'b1;
  assign wr_ent.big  = fill_large;
  assign wr_ent.ro   = fill_ro;
  assign wr_ent.vtag = fill_va[ADDR_W-1:SMALL_SH];
  assign wr_ent.ptag = fill_pa[ADDR_W-1:SMALL_SH];

  tlb_victim #(.N_ENT(N_ENT)) u_vic (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .take(fill_take),
    .vic_idx(fill_idx), .all_valid(all_valid)
  );

  tlb_store #(.N_ENT(N_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(fill_take), .wr_idx(fill_idx),
    .wr_ent(wr_ent), .clr_all(flush_all), .ents(ents), .valid_vec(valid_vec)
  );

  tlb_match #(.N_ENT(N_ENT)) u_match (
    .ents(ents), .va(lk_va), .hit_any(m_hit), .multi(m_multi),
    .pa_sel(m_pa), .ro_sel(m_ro)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
    end else begin
      rsp_vld   <= lk_req;
      rsp_hit   <= lk_req && m_hit;
      rsp_pa    <= (lk_req && m_hit) ? m_pa : '0;
      rsp_fault <= lk_req && m_hit && m_ro && lk_store;
      rsp_multi <= lk_req && m_multi;
    end
  end
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             rsp_vld,
  input logic             rsp_hit,
  input logic [39:0]      rsp_pa,
  input logic             rsp_fault,
  input logic             rsp_multi,
  input logic             flush_all,
  input logic             fill_take,
  input logic [IDX_W-1:0] fill_idx,
  input logic [N_ENT-1:0] valid_vec,
  input logic             all_valid
);
  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_vld);
  // R5
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  // R10
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);
  // R6
  miss_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pa == '0));
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
  // R7
  fill_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take && !all_valid) |-> !valid_vec[fill_idx]);
  // R7
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> valid_vec[$past(fill_idx)]);
endmodule

bind xlate_tlb xlt_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .rsp_vld(rsp_vld),
  .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .rsp_multi(rsp_multi), .flush_all(flush_all), .fill_take(fill_take),
  .fill_idx(fill_idx), .valid_vec(valid_vec), .all_valid(all_valid)
);

// File: tb/sim_xlate_tlb.sv
module sim_xlate_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0, lk_store = 1'b0;
  logic [39:0] lk_va = '0;
  logic        fill_en = 1'b0, fill_large = 1'b0, fill_ro = 1'b0, flush_all = 1'b0;
  logic [39:0] fill_va = '0, fill_pa = '0;
  logic        rsp_vld, rsp_hit, rsp_fault, rsp_multi;
  logic [39:0] rsp_pa;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xlate_tlb u0 (.*);

  // Bench's own view of translation: keep the page bits of pa, offset of va
  function automatic logic [39:0] xl(logic [39:0] pa, logic [39:0] va, bit big);
    logic [39:0] m;
    m = big ? 40'h7FFFF : 40'hFFF;
    return (pa & ~m) | (va & m);
  endfunction

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill(logic [39:0] va, logic [39:0] pa, bit big, bit ro);
    @(negedge clk);
    fill_en = 1; fill_va = va; fill_pa = pa; fill_large = big; fill_ro = ro;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic look(string tag, logic [39:0] va, bit st, bit eh, logic [39:0] epa,
                      bit ef, bit em);
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_store = st;
    @(negedge clk);
    lk_req = 0; lk_store = 0;
    chk({tag, " vld"}, 40'(rsp_vld), 40'd1);
    chk({tag, " hit"}, 40'(rsp_hit), 40'(eh));
    chk({tag, " pa"}, rsp_pa, eh ? epa : 40'h0);
    chk({tag, " fault"}, 40'(rsp_fault), 40'(ef));
    chk({tag, " multi"}, 40'(rsp_multi), 40'(em));
  endtask

  task automatic t_reset();
    chk("R1 vld", 40'(rsp_vld), 0);
    chk("R1 hit", 40'(rsp_hit), 0);
    chk("R1 pa", rsp_pa, 0);
    look("R1 R6 miss", 40'h00_0000_0000, 1, 0, 0, 0, 0);
    look("R1 R6 miss2", 40'h12_3456_7ABC, 0, 0, 0, 0, 0);
  endtask

  task automatic t_small();
    flush();
    fill(40'h12_3456_7000, 40'hAB_CDEF_1000, 0, 0);
    look("R3 small", 40'h12_3456_7ABC, 0, 1, xl(40'hAB_CDEF_1000, 40'h12_3456_7ABC, 0), 0, 0);
    look("R3 small top", 40'h12_3456_7FFF, 0, 1, 40'hAB_CDEF_1FFF, 0, 0);
    look("R6 neighbour miss", 40'h12_3456_8ABC, 0, 0, 0, 0, 0);
  endtask

  task automatic t_large();
    fill(40'h40_000B_5000, 40'h77_0018_3000, 1, 0);
    look("R4 large", 40'h40_000F_FFF8, 0, 1, xl(40'h77_0018_0000, 40'h40_000F_FFF8, 1), 0, 0);
    look("R4 large low", 40'h40_0008_0004, 0, 1, 40'h77_0018_0004, 0, 0);
    look("R4 large out", 40'h40_0010_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_perm();
    fill(40'h20_0000_1000, 40'h30_0000_2000, 0, 1);
    look("R5 ro load", 40'h20_0000_1040, 0, 1, 40'h30_0000_2040, 0, 0);
    look("R5 ro store", 40'h20_0000_1040, 1, 1, 40'h30_0000_2040, 1, 0);
    look("R5 rw store", 40'h12_3456_7010, 1, 1, 40'hAB_CDEF_1010, 0, 0);
    look("R5 miss store", 40'h21_0000_0000, 1, 0, 0, 0, 0);
  endtask

  task automatic t_multi();
    fill(40'h55_0000_0000, 40'h01_0000_0000, 0, 0);
    fill(40'h55_0000_0000, 40'h02_0000_0000, 1, 1);
    look("R10 overlap", 40'h55_0000_0123, 1, 1, 40'h01_0000_0123, 0, 1);
    look("R10 single", 40'h55_0000_1123, 0, 1, 40'h02_0000_1123, 0, 0);
  endtask

  task automatic t_same();
    @(negedge clk);
    fill_en = 1; fill_va = 40'h66_0000_0000; fill_pa = 40'h09_0000_0000;
    fill_large = 0; fill_ro = 0; lk_req = 1; lk_va = 40'h66_0000_0044;
    @(negedge clk);
    fill_en = 0; lk_req = 0;
    chk("R2 fill same cycle hit", 40'(rsp_hit), 0);
    look("R2 fill seen later", 40'h66_0000_0044, 0, 1, 40'h09_0000_0044, 0, 0);
    @(negedge clk);
    flush_all = 1; lk_req = 1; lk_va = 40'h66_0000_0044;
    @(negedge clk);
    flush_all = 0; lk_req = 0;
    chk("R2 R9 flush same cycle hit", 40'(rsp_hit), 1);
    chk("R2 R9 flush same cycle pa", rsp_pa, 40'h09_0000_0044);
    look("R9 after flush", 40'h66_0000_0044, 0, 0, 0, 0, 0);
    look("R9 after flush b", 40'h12_3456_7ABC, 0, 0, 0, 0, 0);
    @(negedge clk);
    flush_all = 1; fill_en = 1; fill_va = 40'h67_0000_0000; fill_pa = 40'h0A_0000_0000;
    @(negedge clk);
    flush_all = 0; fill_en = 0;
    look("R9 fill dropped", 40'h67_0000_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rr();
    flush();
    for (int k = 0; k < 32; k++)
      fill(40'h10_0000_0000 + (40'(k) << 12), 40'h05_0000_0000 + (40'(k) << 12), 0, 0);
    look("R7 slot0", 40'h10_0000_0008, 0, 1, 40'h05_0000_0008, 0, 0);
    look("R7 slot31", 40'h10_0001_F008, 0, 1, 40'h05_0001_F008, 0, 0);
    fill(40'h11_0000_0000, 40'h06_0000_0000, 0, 0);
    look("R8 first victim", 40'h10_0000_0008, 0, 0, 0, 0, 0);
    look("R8 new present", 40'h11_0000_0008, 0, 1, 40'h06_0000_0008, 0, 0);
    look("R8 slot1 kept", 40'h10_0000_1008, 0, 1, 40'h05_0000_1008, 0, 0);
    fill(40'h11_0000_1000, 40'h06_0000_1000, 0, 0);
    look("R8 second victim", 40'h10_0000_1008, 0, 0, 0, 0, 0);
    look("R8 slot2 kept", 40'h10_0000_2008, 0, 1, 40'h05_0000_2008, 0, 0);
    look("R8 first new kept", 40'h11_0000_0008, 0, 1, 40'h06_0000_0008, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_perm();
    t_multi();
    t_same();
    t_rr();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule